// File: doc/BRIEF.md
# Per-Warp Barrier-Slot Issue Gate

This block holds the issue-readiness state of a single warp. Each instruction comes with a 21-bit control word prepared by the compiler. The block splits that word into operand-reuse flags, a slot wait mask, two slot indices that are tagged at issue, a yield bit and a fixed-latency stall count. From these fields it decides whether the warp's next instruction may issue.

The block has no register scoreboard and never compares register numbers. Hazards with a fixed latency are covered by a stall down-counter that loads on every issue. Hazards with a variable latency are covered by six single-bit busy slots. An issue sets a slot busy, and a completion pulse that names the slot clears it again.

A warp arbiter outside the block reads `eligible` and `yield_hint` and answers with `issue_grant`. Memory or other long-latency units return the `done_*` pulses. Opcode decoding, routing to execution units and arbitration between warps are handled elsewhere.

Top module: `warp_issue_gate`

## Requirements
- R1: The control word is packed as follows: reuse flags in bits [20:17], wait mask in [16:11], read-tag slot index in [10:8], write-tag slot index in [7:5], yield bit in [4] and stall count in [3:0]. `reuse_flags` shows bits [20:17] while `ctrl_valid` is high and shows zero otherwise.
- R2: Reset clears all six slots and the stall counter. After reset, the first valid word is eligible at once, even when its wait mask is all ones.
- R3: `eligible` is low while any slot selected by a set wait-mask bit (bit i selects slot i) is busy. A zero wait mask ignores every busy slot.
- R4: When several mask bits are set, `eligible` stays low until every selected slot has cleared.
- R5: An issue loads the stall count. `eligible` is then low for exactly that many cycles after the issuing edge. A count of 0 allows issue on consecutive edges, and 15 is the longest gap.
- R6: An issue with a write-tag index from 0 to 5 sets that slot busy from the next cycle on.
- R7: An issue with a read-tag index from 0 to 5 also sets that slot busy.
- R8: Index values 6 and 7 in either tag field set no slot.
- R9: A `done_valid` pulse whose `done_slot` is 0 to 5 clears that slot. A pulse for a slot that is already idle, or for index 6 or 7, changes nothing.
- R10: When an issue sets a slot in the same cycle as a completion pulse for that slot, the slot ends up busy.
- R11: `yield_hint` goes high in the cycle after an issue whose yield bit is 1. It stays high until the next issue, which sets it to that instruction's yield bit.
- R12: `issue_grant` while `eligible` is low has no effect: it tags no slot and loads no stall count.
- R13: `eligible` is low whenever `ctrl_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 21 | Control word of the warp's next instruction |
| ctrl_valid | input | 1 | ctrl_word holds a pending instruction |
| issue_grant | input | 1 | Arbiter issues this warp's instruction this cycle |
| done_valid | input | 1 | A long-latency completion arrives |
| done_slot | input | 3 | Slot index of the completion |
| eligible | output | 1 | Next instruction may issue |
| yield_hint | output | 1 | Last issued instruction asked to yield |
| reuse_flags | output | 4 | Operand-reuse flags of the pending word |

## Verification
Slot state can only be seen through `eligible`, so the bench reads it by presenting probe words whose wait mask selects one slot at a time. This shows which slots an issue tagged and which ones a completion released. The probes vary the wait mask: a zero mask, a single bit, and two bits released one at a time. Together these separate the any-busy condition from the all-clear condition. The tag fields are tried with in-range indices, with the unassigned values 6 and 7, and with a completion in the same cycle as an issue, so a wrong index decode and a wrong set/clear priority each show up. Stall counts of 0, 3 and 15 are counted cycle by cycle, which catches an off-by-one in the down-counter as well as a grant that is ignored by the design but still leaves state behind.

// File: rtl/warp_issue_gate.sv
module warp_issue_gate #(
  parameter int NSLOT   = 6,
  parameter int IDX_W   = 3,
  parameter int STALL_W = 4,
  parameter int REUSE_W = 4
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic [REUSE_W+NSLOT+2*IDX_W+1+STALL_W-1:0]    ctrl_word,
  input  logic                                          ctrl_valid,
  input  logic                                          issue_grant,
  input  logic                                          done_valid,
  input  logic [IDX_W-1:0]                              done_slot,
  output logic                                          eligible,
  output logic                                          yield_hint,
  output logic [REUSE_W-1:0]                            reuse_flags
);

  localparam int ST_LO = 0;
  localparam int Y_BIT = ST_LO + STALL_W;
  localparam int WR_LO = Y_BIT + 1;
  localparam int RD_LO = WR_LO + IDX_W;
  localparam int WM_LO = RD_LO + IDX_W;
  localparam int RU_LO = WM_LO + NSLOT;

  logic [NSLOT-1:0]   busy_q, set_vec, clr_vec;
  logic [STALL_W-1:0] stall_q;
  logic               yield_q;

  wire [NSLOT-1:0]   wait_mask = ctrl_word[WM_LO +: NSLOT];
  wire [IDX_W-1:0]   rd_idx    = ctrl_word[RD_LO +: IDX_W];
  wire [IDX_W-1:0]   wr_idx    = ctrl_word[WR_LO +: IDX_W];
  wire [STALL_W-1:0] stall_cnt = ctrl_word[ST_LO +: STALL_W];
  wire               yield_bit = ctrl_word[Y_BIT];

  wire blocked = |(wait_mask & busy_q);
  assign eligible    = ctrl_valid && !blocked && (stall_q == '0);
  wire issue = issue_grant && eligible;

  assign reuse_flags = ctrl_valid ? ctrl_word[RU_LO +: REUSE_W] : '0;
  assign yield_hint  = yield_q;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign set_vec[i] = issue && ((rd_idx == IDX_W'(i)) || (wr_idx == IDX_W'(i)));
    assign clr_vec[i] = done_valid && (done_slot == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= '0;
      stall_q <= '0;
      yield_q <= 1'b0;
    end else begin
      busy_q <= (busy_q & ~clr_vec) | set_vec;
      if (issue) begin
        stall_q <= stall_cnt;
        yield_q <= yield_bit;
      end else if (stall_q != '0) begin
        stall_q <= stall_q - 1'b1;
      end
    end
  end

  p_reset_idle_r2: assert property (@(posedge clk)
    !rst_n |=> (busy_q == '0) && (stall_q == '0) && !yield_hint);

  p_wr_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (wr_idx < IDX_W'(NSLOT)) |=> busy_q[$past(wr_idx)]);

  p_rd_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (rd_idx < IDX_W'(NSLOT)) |=> busy_q[$past(rd_idx)]);

  p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && (done_slot < IDX_W'(NSLOT)) && !issue |=> !busy_q[$past(done_slot)]);

  p_stall_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (stall_cnt != '0) |=> !eligible);

  p_stall_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_q != '0) |=> stall_q == $past(stall_q) - 1'b1);

  p_yield_r11: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> yield_hint == $past(yield_bit));

  p_no_grant_effect_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !issue && !done_valid |=> $stable(busy_q));

  p_invalid_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_valid |-> !eligible);

endmodule

// File: tb/warp_issue_gate_test.sv
module warp_issue_gate_test;
  logic clk = 0, rst_n = 0;
  logic [20:0] ctrl_word = '0;
  logic ctrl_valid = 0, issue_grant = 0, done_valid = 0;
  logic [2:0] done_slot = '0;
  logic eligible, yield_hint;
  logic [3:0] reuse_flags;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  warp_issue_gate uut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .ctrl_valid(ctrl_valid),
    .issue_grant(issue_grant), .done_valid(done_valid), .done_slot(done_slot),
    .eligible(eligible), .yield_hint(yield_hint), .reuse_flags(reuse_flags));

  function automatic logic [20:0] mk(input logic [3:0] ru, input logic [5:0] wm,
      input logic [2:0] rd, input logic [2:0] wr, input logic y, input logic [3:0] st);
    return {ru, wm, rd, wr, y, st};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic probe(input int s, input bit busy, input string req);
    ctrl_word = mk(0, 6'(1 << s), 7, 7, 0, 0); ctrl_valid = 1; issue_grant = 0;
    #1 chk(req, eligible, !busy);
  endtask

  task automatic issue(input logic [20:0] w, input string req);
    ctrl_word = w; ctrl_valid = 1; issue_grant = 1;
    #1 chk(req, eligible, 1);
    tick(); issue_grant = 0;
  endtask

  task automatic done(input int s);
    done_valid = 1; done_slot = 3'(s); tick(); done_valid = 0;
  endtask

  task automatic t_reset();
    ctrl_valid = 0; #1 chk("R13 invalid", eligible, 0);
    chk("R1 reuse when invalid", reuse_flags, 0);
    ctrl_word = mk(4'hA, 6'h3F, 7, 7, 0, 0); ctrl_valid = 1;
    #1 chk("R2 eligible after reset", eligible, 1);
    chk("R1 reuse field", reuse_flags, 4'hA);
    chk("R2 yield after reset", yield_hint, 0);
  endtask

  task automatic t_write_tag();
    issue(mk(0, 0, 7, 2, 0, 0), "R6 issue");
    probe(2, 1, "R6 slot2 busy");
    probe(1, 0, "R6 slot1 idle");
    ctrl_word = mk(0, 0, 7, 7, 0, 0); #1 chk("R3 zero mask", eligible, 1);
    done(2); probe(2, 0, "R9 slot2 cleared");
  endtask

  task automatic t_read_tag();
    issue(mk(0, 0, 4, 7, 0, 0), "R7 issue");
    probe(4, 1, "R7 slot4 busy");
    done(4); probe(4, 0, "R7 slot4 cleared");
  endtask

  task automatic t_multi();
    issue(mk(0, 0, 7, 0, 0, 0), "R4 issue a");
    issue(mk(0, 0, 7, 1, 0, 0), "R4 issue b");
    ctrl_word = mk(0, 6'b000011, 7, 7, 0, 0); #1 chk("R4 both busy", eligible, 0);
    done(0); #1 chk("R4 one busy", eligible, 0);
    done(1); #1 chk("R4 all clear", eligible, 1);
  endtask

  task automatic t_unassigned();
    issue(mk(0, 0, 6, 7, 0, 0), "R8 issue");
    for (int s = 0; s < 6; s++) probe(s, 0, "R8 no slot set");
  endtask

  task automatic t_idle_clear();
    done(3); probe(3, 0, "R9 idle clear");
    issue(mk(0, 0, 7, 5, 0, 0), "R9 issue");
    done(6); probe(5, 1, "R9 index 6 ignored");
    done(5); probe(5, 0, "R9 slot5 cleared");
  endtask

  task automatic t_collide();
    issue(mk(0, 0, 7, 1, 0, 0), "R10 first");
    done_valid = 1; done_slot = 1;
    issue(mk(0, 0, 7, 1, 0, 0), "R10 busy slot");
    done_valid = 0; probe(1, 1, "R10 set wins busy");
    done_valid = 1; done_slot = 3;
    issue(mk(0, 0, 7, 3, 0, 0), "R10 idle slot");
    done_valid = 0; probe(3, 1, "R10 set wins idle");
    done(1); done(3);
    probe(1, 0, "R10 cleanup"); probe(3, 0, "R10 cleanup");
  endtask

  task automatic t_stall(input int n);
    issue(mk(0, 0, 7, 7, 0, 4'(n)), "R5 issue");
    ctrl_word = mk(0, 0, 7, 7, 0, 0);
    for (int c = 0; c < n; c++) begin
      #1 chk($sformatf("R5 stall %0d cycle %0d", n, c), eligible, 0);
      tick();
    end
    #1 chk($sformatf("R5 stall %0d end", n), eligible, 1);
  endtask

  task automatic t_back_to_back();
    issue(mk(0, 0, 7, 7, 0, 0), "R5 b2b first");
    issue(mk(0, 0, 7, 7, 0, 0), "R5 b2b second");
  endtask

  task automatic t_grant_ignored();
    issue(mk(0, 0, 7, 2, 0, 0), "R12 setup");
    ctrl_word = mk(0, 6'b000100, 7, 4, 0, 5); issue_grant = 1;
    #1 chk("R12 blocked", eligible, 0);
    tick(); issue_grant = 0;
    probe(4, 0, "R12 no tag");
    ctrl_word = mk(0, 0, 7, 7, 0, 0); #1 chk("R12 no stall", eligible, 1);
    done(2);
  endtask

  task automatic t_yield();
    issue(mk(0, 0, 7, 7, 1, 0), "R11 issue y");
    #1 chk("R11 yield set", yield_hint, 1);
    ctrl_valid = 0; tick();
    #1 chk("R11 yield held", yield_hint, 1);
    issue(mk(0, 0, 7, 7, 0, 0), "R11 issue n");
    #1 chk("R11 yield cleared", yield_hint, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    t_reset();
    t_write_tag();
    t_read_tag();
    t_multi();
    t_unassigned();
    t_idle_clear();
    t_collide();
    t_back_to_back();
    t_stall(3);
    t_stall(15);
    t_grant_ignored();
    t_yield();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule